// File: doc/BRIEF.md
# CAN Bit Stuffing Encoder and Decoder

This block holds the two serial filters that sit between a CAN frame sequencer and the bit-timing logic. The transmit filter takes the unstuffed frame bit stream one bit per bit-time strobe. When five equal bits have gone out, it adds one bit of the opposite value. The receive filter does the reverse on the incoming line. It drops each stuff bit, marks that slot as carrying no data, and reports a stuff error when the expected complement does not arrive.

The frame sequencer drives a region flag beside each unstuffed bit. The flag is high from the dominant start-of-frame bit to the last CRC bit. It is low for the fixed-form tail: the CRC delimiter, the acknowledge slot and the seven recessive end-of-frame bits. A stuff bit that is due after the last CRC bit is still added (or expected), because the decision looks at the region of the previous bit. A start-of-frame marker clears the run state in both directions. On the transmit side, a stall output tells the sequencer that the bit it offered was not taken and must be offered again at the next strobe.

Top module: `canBitStuff`

## Requirements
- R1: After reset, txOut is 1 (recessive), txStall is 0, rxData is 1, rxValid is 0 and rxStuffErr is 0.
- R2: The transmit filter counts equal bits that it has sent inside the region. When the previous bit was in the region and closed a run of RUN_LEN (default 5), the next strobe sends the complement instead of txIn, and txStall is high for that bit time. The offered bit is not consumed and goes out at the following strobe.
- R3: A stuff bit is the first bit of the next run. For example, five 0s, a stuffed 1, then four more 1s from the input give a second stuffed 0.
- R4: A bit presented with the region flag low is never followed by a stuff bit. The seven-bit recessive end-of-frame therefore goes out unchanged. A stuff bit owed after the last in-region bit is still sent, even if the bit offered next has its region flag low.
- R5: A strobe with the start-of-frame flag high (bit value 0) restarts the run at one, whatever the earlier history. No stuff bit is added in front of it.
- R6: When a stuff bit is due, the receive filter drops it: rxValid stays 0 for that slot and rxData keeps its value. Every other slot gives rxValid = 1 with rxData equal to the received bit.
- R7: When a stuff bit is due and the received bit equals the last bit of the run (a sixth equal bit), rxStuffErr pulses for one clock, rxValid stays 0, and the run restarts at that bit.
- R8: Outputs change on the clock edge that samples a strobe. txOut and txStall hold until the next strobe. rxValid and rxStuffErr are single-clock pulses.
- R9: Six or more equal bits received with the region flag low give no stuff error, and every one of them is passed with rxValid = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitEn | input | 1 | One-clock strobe per nominal bit time, shared by both filters |
| txIn | input | 1 | Unstuffed bit offered by the sequencer |
| txSof | input | 1 | Offered bit is start-of-frame |
| txRegion | input | 1 | Offered bit lies in the stuffed region |
| txOut | output | 1 | Stuffed bit to the line (1 = recessive) |
| txStall | output | 1 | Current output is a stuff bit; the offered bit was not taken |
| rxIn | input | 1 | Bit sampled from the line |
| rxSof | input | 1 | Received bit is start-of-frame |
| rxRegion | input | 1 | Received data bit lies in the stuffed region |
| rxData | output | 1 | Destuffed data bit |
| rxValid | output | 1 | Pulse: rxData carries a new data bit |
| rxStuffErr | output | 1 | Pulse: a sixth equal bit arrived where a stuff bit was due |

## Verification
The assertions assume the following about the inputs:
- bitEn is a strobe.
- While txStall is high, the sequencer keeps offering the same bit.
- The start-of-frame flag comes only with a dominant bit.
- RUN_LEN is at least two, so two stuff bits can never follow each other.

The stimulus stays within these limits. It pulses bitEn once every four clocks and advances the transmit source only on unstalled strobes. It raises the start-of-frame flag only on the first bit of each frame. Random frames are built from runs of one to eight equal bits, so runs both shorter and longer than the stuff limit occur. Some stuffed streams are corrupted so that a stuff slot carries the wrong value, which drives the receive error path.

// File: rtl/canStuffPkg.sv
package canStuffPkg;

  // Strobes from the control module to the output registers.
  typedef struct packed {
    logic txLoad;     // transmit strobe this clock
    logic txIsStuff;  // transmit slot carries a stuff bit
    logic txBit;      // value to drive on the line
    logic rxLoad;     // receive strobe this clock
    logic rxPass;     // receive slot carries data
    logic rxBit;      // received value
    logic rxErr;      // sixth equal bit where a stuff bit was due
  } stuffStrobes_t;

endpackage

// File: rtl/canRunTrack.sv
module canRunTrack #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic step,
  input  logic sof,
  input  logic bitVal,
  input  logic region,
  input  logic isStuff,
  output logic runFull,
  output logic lastBit,
  output logic lastRegion
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] RUN_ONE = CNT_W'(1);

  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt     <= '0;
      lastBit    <= 1'b1;
      lastRegion <= 1'b0;
    end else if (step) begin
      if (isStuff) begin
        // The stuff bit opens a new run; the region flag of the data bit is kept.
        runCnt  <= RUN_ONE;
        lastBit <= bitVal;
      end else begin
        lastBit    <= bitVal;
        lastRegion <= region;
        if (sof || !region || (bitVal != lastBit)) begin
          runCnt <= RUN_ONE;
        end else if (runCnt != RUN_MAX) begin
          runCnt <= runCnt + RUN_ONE;
        end
      end
    end
  end

  assign runFull = (runCnt == RUN_MAX);

  // R3: once a stuff bit is taken, the run is no longer full.
  p_run_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    (step && isStuff) |=> !runFull);

endmodule

// File: rtl/canStuffCtrl.sv
module canStuffCtrl
  import canStuffPkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitEn,
  input  logic          txIn,
  input  logic          txSof,
  input  logic          txRegion,
  input  logic          rxIn,
  input  logic          rxSof,
  input  logic          rxRegion,
  output stuffStrobes_t strobes
);

  localparam int LANES = 2;  // lane 0 transmit, lane 1 receive
  localparam int TXL   = 0;
  localparam int RXL   = 1;

  logic [LANES-1:0] laneSof, laneBit, laneRegion, laneStuff;
  logic [LANES-1:0] laneFull, laneLast, laneLastRegion;

  logic txStuffNow;
  logic rxExpectStuff;

  // A stuff slot is due when the previous bit was in the region and closed a full run.
  assign txStuffNow    = laneFull[TXL] && laneLastRegion[TXL] && !txSof;
  assign rxExpectStuff = laneFull[RXL] && laneLastRegion[RXL] && !rxSof;

  always_comb begin
    laneSof[TXL]    = txSof;
    laneRegion[TXL] = txRegion;
    laneStuff[TXL]  = txStuffNow;
    laneBit[TXL]    = txStuffNow ? ~laneLast[TXL] : txIn;

    laneSof[RXL]    = rxSof;
    laneRegion[RXL] = rxRegion;
    laneStuff[RXL]  = rxExpectStuff;
    laneBit[RXL]    = rxIn;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    canRunTrack #(.RUN_LEN(RUN_LEN)) u_track (
      .clk        (clk),
      .rstN       (rstN),
      .step       (bitEn),
      .sof        (laneSof[g]),
      .bitVal     (laneBit[g]),
      .region     (laneRegion[g]),
      .isStuff    (laneStuff[g]),
      .runFull    (laneFull[g]),
      .lastBit    (laneLast[g]),
      .lastRegion (laneLastRegion[g])
    );
  end

  always_comb begin
    strobes.txLoad    = bitEn;
    strobes.txIsStuff = txStuffNow;
    strobes.txBit     = laneBit[TXL];
    strobes.rxLoad    = bitEn;
    strobes.rxPass    = !rxExpectStuff;
    strobes.rxBit     = rxIn;
    strobes.rxErr     = rxExpectStuff && (rxIn == laneLast[RXL]);
  end

endmodule

// File: rtl/canStuffPath.sv
module canStuffPath
  import canStuffPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  stuffStrobes_t strobes,
  output logic          txOut,
  output logic          txStall,
  output logic          rxData,
  output logic          rxValid,
  output logic          rxStuffErr
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOut      <= 1'b1;
      txStall    <= 1'b0;
      rxData     <= 1'b1;
      rxValid    <= 1'b0;
      rxStuffErr <= 1'b0;
    end else begin
      rxValid    <= 1'b0;
      rxStuffErr <= 1'b0;
      if (strobes.txLoad) begin
        txOut   <= strobes.txBit;
        txStall <= strobes.txIsStuff;
      end
      if (strobes.rxLoad) begin
        rxValid    <= strobes.rxPass;
        rxStuffErr <= strobes.rxErr;
        if (strobes.rxPass) begin
          rxData <= strobes.rxBit;
        end
      end
    end
  end

  // R2: a stuff slot inverts the line relative to the bit before it.
  p_stuff_flips_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.txLoad && strobes.txIsStuff) |=> (txStall && (txOut != $past(txOut))));

  // R3: two stuff bits never follow each other.
  p_no_double_stuff_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.txLoad && txStall) |=> !txStall);

  // R7: an errored slot never carries data.
  p_err_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxStuffErr |-> !rxValid);

  // R8: the error indication is a single-clock pulse.
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxStuffErr |=> !rxStuffErr);

endmodule

// File: rtl/canBitStuff.sv
module canBitStuff
  import canStuffPkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitEn,
  input  logic txIn,
  input  logic txSof,
  input  logic txRegion,
  output logic txOut,
  output logic txStall,
  input  logic rxIn,
  input  logic rxSof,
  input  logic rxRegion,
  output logic rxData,
  output logic rxValid,
  output logic rxStuffErr
);

  stuffStrobes_t strobes;

  canStuffCtrl #(.RUN_LEN(RUN_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitEn    (bitEn),
    .txIn     (txIn),
    .txSof    (txSof),
    .txRegion (txRegion),
    .rxIn     (rxIn),
    .rxSof    (rxSof),
    .rxRegion (rxRegion),
    .strobes  (strobes)
  );

  canStuffPath u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .txOut      (txOut),
    .txStall    (txStall),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .rxStuffErr (rxStuffErr)
  );

endmodule

// File: tb/canBitStuff_bench.sv
`timescale 1ns/1ps
module canBitStuff_bench;

  localparam int RUN = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic txIn = 1'b1, txSof = 1'b0, txRegion = 1'b0;
  logic rxIn = 1'b1, rxSof = 1'b0, rxRegion = 1'b0;
  logic txOut, txStall, rxData, rxValid, rxStuffErr;

  always #10 clk = ~clk;  // 50 MHz

  canBitStuff #(.RUN_LEN(RUN)) u_canBitStuff (
    .clk(clk), .rstN(rstN), .bitEn(bitEn),
    .txIn(txIn), .txSof(txSof), .txRegion(txRegion),
    .txOut(txOut), .txStall(txStall),
    .rxIn(rxIn), .rxSof(rxSof), .rxRegion(rxRegion),
    .rxData(rxData), .rxValid(rxValid), .rxStuffErr(rxStuffErr)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  // Unstuffed source, stuffed slots and expected receive results.
  bit iBits[$], iReg[$], iSof[$];
  bit oBits[$], oStuff[$], oReg[$], oSof[$];
  bit eValid[$], eData[$], eErr[$];

  // Model run state per lane: 0 transmit, 1 receive, 2 stream generator.
  int mCnt[3];
  bit mLast[3];
  bit mLreg[3];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      $display("FAIL R8 watchdog expired: actual=%0d cycles expected<=150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearSrc();
    iBits.delete(); iReg.delete(); iSof.delete();
  endtask

  task automatic pushSrc(input bit b, input bit r, input bit s, input int n);
    for (int k = 0; k < n; k++) begin
      iBits.push_back(b); iReg.push_back(r); iSof.push_back(s);
    end
  endtask

  // Stuffing rule: a complement is due when the previous bit was in the region
  // and closed a run of RUN equal bits; the stuff bit starts a new run.
  task automatic modelStuff(input int lane);
    oBits.delete(); oStuff.delete(); oReg.delete(); oSof.delete();
    for (int i = 0; i < iBits.size(); i++) begin
      if (!iSof[i] && mCnt[lane] == RUN && mLreg[lane]) begin
        mLast[lane] = ~mLast[lane];
        mCnt[lane] = 1;
        oBits.push_back(mLast[lane]); oStuff.push_back(1'b1);
        oReg.push_back(iReg[i]); oSof.push_back(1'b0);
      end
      if (iSof[i] || !iReg[i] || iBits[i] != mLast[lane]) mCnt[lane] = 1;
      else if (mCnt[lane] < RUN) mCnt[lane]++;
      mLast[lane] = iBits[i];
      mLreg[lane] = iReg[i];
      oBits.push_back(iBits[i]); oStuff.push_back(1'b0);
      oReg.push_back(iReg[i]); oSof.push_back(iSof[i]);
    end
  endtask

  // Receive rule applied to the slot stream held in o*.
  task automatic modelRx();
    eValid.delete(); eData.delete(); eErr.delete();
    for (int k = 0; k < oBits.size(); k++) begin
      if (!oSof[k] && mCnt[1] == RUN && mLreg[1]) begin
        eValid.push_back(1'b0); eData.push_back(1'b0);
        eErr.push_back(oBits[k] == mLast[1]);
        mCnt[1] = 1;
        mLast[1] = oBits[k];
      end else begin
        eValid.push_back(1'b1); eData.push_back(oBits[k]); eErr.push_back(1'b0);
        if (oSof[k] || !oReg[k] || oBits[k] != mLast[1]) mCnt[1] = 1;
        else if (mCnt[1] < RUN) mCnt[1]++;
        mLast[1] = oBits[k];
        mLreg[1] = oReg[k];
      end
    end
  endtask

  // Random frame: dominant SOF, runs of 1..8 equal bits in region, recessive tail.
  task automatic makeFrame();
    int target;
    clearSrc();
    pushSrc(1'b0, 1'b1, 1'b1, 1);
    target = $urandom_range(70, 20);
    while (iBits.size() < target) begin
      pushSrc(1'($urandom_range(1, 0)), 1'b1, 1'b0, $urandom_range(8, 1));
    end
    pushSrc(1'b1, 1'b0, 1'b0, 10);
  endtask

  task automatic runTx(input string tag);
    int idx = 0;
    for (int k = 0; k < oBits.size(); k++) begin
      @(negedge clk);
      txIn = iBits[idx]; txRegion = iReg[idx]; txSof = iSof[idx];
      bitEn = 1'b1;
      @(negedge clk);
      bitEn = 1'b0; txSof = 1'b0;
      chk(oStuff[k] ? "R2" : tag, "txOut", txOut, oBits[k]);
      chk("R2", "txStall", txStall, oStuff[k]);
      @(negedge clk);
      chk("R8", "txOut hold", txOut, oBits[k]);
      if (!txStall && idx < iBits.size() - 1) idx++;
      @(negedge clk);
    end
  endtask

  task automatic runRx(input string tag);
    for (int k = 0; k < oBits.size(); k++) begin
      @(negedge clk);
      rxIn = oBits[k]; rxRegion = oReg[k]; rxSof = oSof[k];
      bitEn = 1'b1;
      @(negedge clk);
      bitEn = 1'b0; rxSof = 1'b0;
      chk(tag, "rxValid", rxValid, eValid[k]);
      chk(eErr[k] ? "R7" : tag, "rxStuffErr", rxStuffErr, eErr[k]);
      if (eValid[k]) chk(tag, "rxData", rxData, eData[k]);
      @(negedge clk);
      chk("R8", "rxValid pulse", rxValid, 0);
      chk("R8", "rxStuffErr pulse", rxStuffErr, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    int seedVal;
    seedVal = $urandom(32'd20240611);
    mCnt[0] = 0; mCnt[1] = 0; mCnt[2] = 0;
    mLast[0] = 1'b1; mLast[1] = 1'b1; mLast[2] = 1'b1;
    mLreg[0] = 1'b0; mLreg[1] = 1'b0; mLreg[2] = 1'b0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "txOut", txOut, 1);
    chk("R1", "txStall", txStall, 0);
    chk("R1", "rxData", rxData, 1);
    chk("R1", "rxValid", rxValid, 0);
    chk("R1", "rxStuffErr", rxStuffErr, 0);

    // R3: five 0s, stuffed 1, four 1s, second stuff 0
    clearSrc();
    pushSrc(1'b0, 1'b1, 1'b1, 1);
    pushSrc(1'b0, 1'b1, 1'b0, 4);
    pushSrc(1'b1, 1'b1, 1'b0, 4);
    pushSrc(1'b0, 1'b1, 1'b0, 1);
    pushSrc(1'b1, 1'b0, 1'b0, 10);
    modelStuff(0);
    chk("R3", "model stuff count", int'(oStuff[5]) + int'(oStuff[10]), 2);
    runTx("R3");

    // R4: stuff owed after last in-region bit, none in the recessive tail
    clearSrc();
    pushSrc(1'b0, 1'b1, 1'b1, 1);
    pushSrc(1'b1, 1'b1, 1'b0, 5);
    pushSrc(1'b1, 1'b0, 1'b0, 10);
    pushSrc(1'b0, 1'b0, 1'b0, 7);
    modelStuff(0);
    runTx("R4");

    // R5: start-of-frame clears a pending run of 0s
    clearSrc();
    pushSrc(1'b1, 1'b1, 1'b0, 1);
    pushSrc(1'b0, 1'b1, 1'b0, 3);
    pushSrc(1'b0, 1'b1, 1'b1, 1);
    pushSrc(1'b0, 1'b1, 1'b0, 2);
    pushSrc(1'b1, 1'b1, 1'b0, 1);
    pushSrc(1'b1, 1'b0, 1'b0, 10);
    modelStuff(0);
    runTx("R5");

    // R2: random frames through the transmit filter
    for (int f = 0; f < 20; f++) begin
      makeFrame();
      modelStuff(0);
      runTx("R2");
    end

    // R6: a stuffed 1 after five 0s is dropped
    clearSrc();
    pushSrc(1'b0, 1'b1, 1'b1, 1);
    pushSrc(1'b0, 1'b1, 1'b0, 4);
    pushSrc(1'b1, 1'b1, 1'b0, 1);
    pushSrc(1'b0, 1'b1, 1'b0, 1);
    pushSrc(1'b1, 1'b0, 1'b0, 8);
    mCnt[2] = 0; mLast[2] = 1'b1; mLreg[2] = 1'b0;
    modelStuff(2);
    modelRx();
    chk("R6", "model drop slot", eValid[5], 0);
    runRx("R6");

    // R7: a sixth 0 where a stuff bit is due
    oBits.delete(); oStuff.delete(); oReg.delete(); oSof.delete();
    for (int k = 0; k < 12; k++) begin
      oBits.push_back(k < 6 ? 1'b0 : 1'b1);
      oReg.push_back(k < 6);
      oSof.push_back(k == 0);
      oStuff.push_back(1'b0);
    end
    modelRx();
    chk("R7", "model error slot", eErr[5], 1);
    runRx("R7");

    // R9: seven 0s outside the region pass untouched
    oBits.delete(); oStuff.delete(); oReg.delete(); oSof.delete();
    for (int k = 0; k < 9; k++) begin
      oBits.push_back(k < 7 ? 1'b0 : 1'b1);
      oReg.push_back(1'b0); oSof.push_back(1'b0); oStuff.push_back(1'b0);
    end
    modelRx();
    runRx("R9");

    // R6/R7: random stuffed frames, some with a corrupted stuff slot
    for (int f = 0; f < 20; f++) begin
      makeFrame();
      mCnt[2] = 0; mLast[2] = 1'b1; mLreg[2] = 1'b0;
      modelStuff(2);
      if ($urandom_range(2, 0) == 0) begin
        for (int k = 1; k < oBits.size(); k++) begin
          if (oStuff[k]) begin
            oBits[k] = oBits[k-1];
            break;
          end
        end
      end
      modelRx();
      runRx("R6");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule